// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames into host buffers under control of a circular list of receive descriptors kept in a small descriptor memory. Each 64-bit descriptor holds a 16-bit status/control word, a 16-bit length and a 32-bit buffer pointer, packed as `{status[63:48], length[47:32], pointer[31:0]}`. The host hands a descriptor to the engine by setting its empty bit. It then writes the poll-kick register. The engine fetches the current descriptor and, if it is empty, stores the next incoming frame byte by byte at the buffer pointer. It then writes the descriptor back with the length and a fresh status, the empty bit cleared.

After each writeback the engine moves to the next descriptor. When the descriptor just used carries the wrap bit, it returns to the ring base instead. It fetches again straight away and keeps going until it finds a descriptor the host has not yet returned. At that point the poll-active flag clears and the engine idles until the next kick. Frames that arrive with no empty descriptor in hand are discarded and reported with an overrun pulse. The reported length includes the 4-byte check sequence, because the input stream carries it.

Top module: `rx_bd_ring_engine`

## Requirements
- R1: While reset is low, and after it until a kick, poll_active, dm_rd, dm_wr, buf_we and ovr_evt are all 0.
- R2: A write to the kick register whose bit 24 is 1 (for example 0x01000000) sets poll_active and starts a fetch at ring base + current index. A write with bit 24 at 0 has no effect.
- R3: With an empty descriptor held, the first byte of a frame goes to the buffer pointer and each following byte to the next byte address. No byte is lost to gaps in in_valid.
- R4: Writeback clears empty (status bit 15) and clears the old low six error bits 5:0. It sets last (bit 11) and keeps every other status bit, including wrap (bit 13). The length field is the number of bytes stored, check sequence included.
- R5: After a writeback the next descriptor is index+1, or index 0 at the ring base when the used descriptor had wrap set. Fetching resumes without a new kick.
- R6: A fetched descriptor with empty at 0 clears poll_active, stops all further fetches and is left unwritten.
- R7: A frame longer than MAX_FRAME (1518) stores only its first MAX_FRAME bytes, reports length MAX_FRAME and sets the long-frame bit 5. A frame of exactly MAX_FRAME bytes does not set it.
- R8: A frame shorter than MIN_FRAME (64) sets the short-frame bit 4. A frame of exactly MIN_FRAME bytes does not set it.
- R9: in_err, sampled with the last byte, sets the frame-error bit 0 of the written status.
- R10: A frame whose first byte arrives while no empty descriptor is held is dropped whole: one ovr_evt pulse, no buffer write and no descriptor write.
- R11: A base-register write takes effect only while the engine is halted, and it resets the ring index to 0. While poll_active is 1 the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| act_wr | input | 1 | Write strobe for the poll-kick register |
| act_wdata | input | 32 | Kick data; bit 24 starts polling |
| base_wr | input | 1 | Write strobe for the ring base register |
| base_wdata | input | DAW | New ring base (descriptor memory index) |
| poll_active | output | 1 | Engine is polling or owns a descriptor |
| dm_rd | output | 1 | Descriptor read; data returns next cycle |
| dm_wr | output | 1 | Descriptor writeback strobe |
| dm_addr | output | DAW | Descriptor memory address |
| dm_wdata | output | 64 | Written-back descriptor |
| dm_rdata | input | 64 | Descriptor read data, one cycle after dm_rd |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of the frame |
| in_err | input | 1 | Frame error, valid with in_last |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_waddr | output | 32 | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| ovr_evt | output | 1 | One-cycle pulse per dropped frame |

## Verification
A wrong ring index shows at the next frame boundary. The descriptor written back sits at the wrong address. An empty sentinel placed just past the wrap entry then keeps poll_active high where it should have fallen within four cycles of the writeback. A stuck or miscounted length counter shows in the written length and in payload bytes at shifted addresses. Both are read back a few cycles after the last byte. A false held-descriptor state shows either as a missing ovr_evt pulse one cycle after the first byte of a frame or as buffer writes the bench counts while the engine should be halted.

// File: rtl/rxr_pkg.sv
// Shared types and field positions for the receive descriptor ring engine.
// Assumes a 64-bit descriptor word: {status, length, buffer pointer}.
package rxr_pkg;

    localparam int ST_EMPTY = 15;   // host sets, engine clears
    localparam int ST_WRAP  = 13;   // last descriptor of the ring
    localparam int ST_LAST  = 11;   // frame ends in this buffer
    localparam int ST_LONG  = 5;    // frame exceeded the length limit
    localparam int ST_SHORT = 4;    // frame below the minimum length
    localparam int ST_FERR  = 0;    // error flagged by the frame source
    localparam int KICK_BIT = 24;   // kick register bit that starts polling

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_CHECK,
        ENG_READY,
        ENG_RECV,
        ENG_WB
    } eng_state_t;

    typedef struct packed {
        logic [15:0] stat;
        logic [15:0] len;
        logic [31:0] buf_ptr;
    } rx_desc_t;

    // Build the written-back descriptor from the held one and the frame result.
    function automatic rx_desc_t wb_word(input rx_desc_t d, input logic [15:0] n,
                                         input logic lg, input logic sh, input logic fe);
        rx_desc_t w;
        w = d;
        w.stat[5:0]      = 6'b0;
        w.stat[ST_EMPTY] = 1'b0;
        w.stat[ST_LAST]  = 1'b1;
        w.stat[ST_LONG]  = lg;
        w.stat[ST_SHORT] = sh;
        w.stat[ST_FERR]  = fe;
        w.len            = n;
        return w;
    endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
// Ring position: holds the ring base and the current descriptor index.
// Assumes base_ld only arrives while the engine is halted (gated by the caller).
module rxr_ring_ptr #(
    parameter int DAW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           base_ld,
    input  logic [DAW-1:0] base_val,
    input  logic           step,
    input  logic           wrap,
    output logic [DAW-1:0] cur_addr
);

    logic [DAW-1:0] base_q;
    logic [DAW-1:0] idx_q;

    // Load a new base (index restarts) or move to the next descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (base_ld) begin
            base_q <= base_val;
            idx_q  <= '0;
        end else if (step) begin
            idx_q  <= wrap ? '0 : idx_q + DAW'(1);
        end
    end

    // Descriptor address is the base offset by the index.
    always_comb cur_addr = base_q + idx_q;

endmodule

// File: rtl/rxr_len_ctr.sv
// Frame byte counter with saturation at the maximum frame length.
// Assumes start and step are never high in the same cycle.
module rxr_len_ctr #(
    parameter int MAX_FRAME = 1518,
    parameter int MIN_FRAME = 64,
    parameter int LW        = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          step,
    output logic [LW-1:0] cnt,
    output logic          room,
    output logic          too_long,
    output logic          too_short
);

    localparam logic [LW-1:0] MAX_LEN = LW'(MAX_FRAME);
    localparam logic [LW-1:0] MIN_LEN = LW'(MIN_FRAME);

    logic [LW-1:0] cnt_q;
    logic          long_q;

    // Count stored bytes; a byte beyond the limit marks the frame long.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            long_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= LW'(1);
            long_q <= 1'b0;
        end else if (step) begin
            if (cnt_q < MAX_LEN) cnt_q  <= cnt_q + LW'(1);
            else                 long_q <= 1'b1;
        end
    end

    // Expose count and the derived length flags.
    always_comb begin
        cnt       = cnt_q;
        room      = cnt_q < MAX_LEN;
        too_long  = long_q;
        too_short = cnt_q < MIN_LEN;
    end

endmodule

// File: rtl/rx_bd_ring_engine.sv
// Receive descriptor ring engine: fetches descriptors on a kick, stores each
// frame into the buffer of an empty descriptor, writes the descriptor back
// and advances around the ring until it meets one the host still owns.
// Assumes descriptor memory read data one cycle after dm_rd, and a byte
// stream that cannot be stalled (no ready signal).
module rx_bd_ring_engine
    import rxr_pkg::*;
#(
    parameter int DAW       = 6,
    parameter int MAX_FRAME = 1518,
    parameter int MIN_FRAME = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           act_wr,
    input  logic [31:0]    act_wdata,
    input  logic           base_wr,
    input  logic [DAW-1:0] base_wdata,
    output logic           poll_active,
    output logic           dm_rd,
    output logic           dm_wr,
    output logic [DAW-1:0] dm_addr,
    output logic [63:0]    dm_wdata,
    input  logic [63:0]    dm_rdata,
    input  logic           in_valid,
    input  logic [7:0]     in_data,
    input  logic           in_last,
    input  logic           in_err,
    output logic           buf_we,
    output logic [31:0]    buf_waddr,
    output logic [7:0]     buf_wdata,
    output logic           ovr_evt
);

    localparam int LW = 16;

    eng_state_t    st_q, st_d;
    logic          active_q;
    rx_desc_t      desc_q;
    rx_desc_t      rdesc;
    logic          mid_q, fe_q, ovr_q;
    logic          start_b, take_first, take_more, kick, base_ok, halt_now;
    logic [LW-1:0] cnt;
    logic          room, too_long, too_short;

    // Decode the frame stream and host strobes against the current state.
    always_comb begin
        rdesc      = rx_desc_t'(dm_rdata);
        start_b    = in_valid & ~mid_q;
        take_first = (st_q == ENG_READY) & start_b;
        take_more  = (st_q == ENG_RECV) & in_valid;
        kick       = act_wr & act_wdata[KICK_BIT];
        base_ok    = base_wr & ~active_q & (st_q == ENG_IDLE);
        halt_now   = (st_q == ENG_CHECK) & ~rdesc.stat[ST_EMPTY];
    end

    rxr_ring_ptr #(.DAW(DAW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_ld  (base_ok),
        .base_val (base_wdata),
        .step     (st_q == ENG_WB),
        .wrap     (desc_q.stat[ST_WRAP]),
        .cur_addr (dm_addr)
    );

    rxr_len_ctr #(.MAX_FRAME(MAX_FRAME), .MIN_FRAME(MIN_FRAME), .LW(LW)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (take_first),
        .step      (take_more),
        .cnt       (cnt),
        .room      (room),
        .too_long  (too_long),
        .too_short (too_short)
    );

    // Next-state logic of the descriptor walk.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ENG_IDLE:  if (active_q) st_d = ENG_FETCH;
            ENG_FETCH: st_d = ENG_CHECK;
            ENG_CHECK: st_d = rdesc.stat[ST_EMPTY] ? ENG_READY : ENG_IDLE;
            ENG_READY: if (take_first) st_d = in_last ? ENG_WB : ENG_RECV;
            ENG_RECV:  if (take_more && in_last) st_d = ENG_WB;
            ENG_WB:    st_d = active_q ? ENG_FETCH : ENG_IDLE;
            default:   st_d = ENG_IDLE;
        endcase
    end

    // State, kick flag, held descriptor, frame tracking and overrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ENG_IDLE;
            active_q <= 1'b0;
            desc_q   <= '0;
            mid_q    <= 1'b0;
            fe_q     <= 1'b0;
            ovr_q    <= 1'b0;
        end else begin
            st_q     <= st_d;
            active_q <= kick | (active_q & ~halt_now);
            if ((st_q == ENG_CHECK) && rdesc.stat[ST_EMPTY]) desc_q <= rdesc;
            if (in_valid) mid_q <= ~in_last;
            if ((take_first || take_more) && in_last) fe_q <= in_err;
            ovr_q    <= start_b & (st_q != ENG_READY);
        end
    end

    // Drive the memory, buffer and status outputs.
    always_comb begin
        poll_active = active_q;
        dm_rd       = (st_q == ENG_FETCH);
        dm_wr       = (st_q == ENG_WB);
        dm_wdata    = wb_word(desc_q, cnt, too_long, too_short, fe_q);
        buf_we      = take_first | (take_more & room);
        buf_waddr   = desc_q.buf_ptr + (take_first ? 32'd0 : 32'(cnt));
        buf_wdata   = in_data;
        ovr_evt     = ovr_q;
    end

endmodule

// File: rtl/rx_bd_ring_engine_chk.sv
// Property checker for the receive descriptor ring engine, bound to the top.
// Assumes it sees only the top-level ports.
module rx_bd_ring_engine_chk
    import rxr_pkg::*;
#(
    parameter int MAX_FRAME = 1518
) (
    input logic        clk,
    input logic        rst_n,
    input logic        act_wr,
    input logic [31:0] act_wdata,
    input logic        poll_active,
    input logic        dm_rd,
    input logic        dm_wr,
    input logic [63:0] dm_wdata,
    input logic        buf_we,
    input logic        ovr_evt
);

    rx_desc_t wb_view;
    always_comb wb_view = rx_desc_t'(dm_wdata);

    assert_kick_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(poll_active) |-> $past(act_wr && act_wdata[KICK_BIT]));

    assert_rd_wr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(dm_rd && dm_wr));

    assert_wb_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dm_wr |-> (!wb_view.stat[ST_EMPTY] && wb_view.stat[ST_LAST]));

    assert_wb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dm_wr |=> !dm_wr);

    assert_no_fetch_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dm_rd |-> poll_active);

    assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dm_wr |-> (int'(wb_view.len) <= MAX_FRAME));

    assert_drop_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |-> !$past(buf_we));

endmodule

bind rx_bd_ring_engine rx_bd_ring_engine_chk #(.MAX_FRAME(MAX_FRAME)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_wr      (act_wr),
    .act_wdata   (act_wdata),
    .poll_active (poll_active),
    .dm_rd       (dm_rd),
    .dm_wr       (dm_wr),
    .dm_wdata    (dm_wdata),
    .buf_we      (buf_we),
    .ovr_evt     (ovr_evt)
);

// File: tb/rx_bd_ring_engine_tb_top.sv
// Bench for the receive descriptor ring engine: models descriptor and buffer
// memories, drives directed corner frames and then a seeded random run.
module rx_bd_ring_engine_tb_top;

    localparam int DAW  = 6;
    localparam int MAXF = 1518;
    localparam int MINF = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           act_wr = 1'b0;
    logic [31:0]    act_wdata = '0;
    logic           base_wr = 1'b0;
    logic [DAW-1:0] base_wdata = '0;
    logic           poll_active, dm_rd, dm_wr, buf_we, ovr_evt;
    logic [DAW-1:0] dm_addr;
    logic [63:0]    dm_wdata;
    logic [63:0]    dm_rdata = '0;
    logic           in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0;
    logic [7:0]     in_data = '0;
    logic [31:0]    buf_waddr;
    logic [7:0]     buf_wdata;

    logic [63:0]    dmem [64];
    logic [7:0]     bmem [2048];
    logic           h_dwe = 1'b0, h_bwe = 1'b0;
    logic [5:0]     h_daddr = '0;
    logic [63:0]    h_ddata = '0;
    logic [10:0]    h_baddr = '0;
    logic [20:0]    hi_seen = '0;

    int n_chk = 0, n_bad = 0, n_dmw = 0, n_bw = 0, n_ovr = 0;

    always #4 clk = ~clk;

    rx_bd_ring_engine #(.DAW(DAW), .MAX_FRAME(MAXF), .MIN_FRAME(MINF)) dut_i (
        .clk(clk), .rst_n(rst_n), .act_wr(act_wr), .act_wdata(act_wdata),
        .base_wr(base_wr), .base_wdata(base_wdata), .poll_active(poll_active),
        .dm_rd(dm_rd), .dm_wr(dm_wr), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
        .dm_rdata(dm_rdata), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_err(in_err), .buf_we(buf_we),
        .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .ovr_evt(ovr_evt)
    );

    // Memory models and event counters.
    always @(posedge clk) begin
        if (dm_rd)  dm_rdata <= dmem[dm_addr];
        if (dm_wr)  dmem[dm_addr] <= dm_wdata;
        if (h_dwe)  dmem[h_daddr] <= h_ddata;
        if (buf_we) begin
            bmem[buf_waddr[10:0]] <= buf_wdata;
            hi_seen <= buf_waddr[31:11];
        end
        if (h_bwe)  bmem[h_baddr] <= 8'hEE;
        if (rst_n) begin
            if (dm_wr)   n_dmw <= n_dmw + 1;
            if (buf_we)  n_bw  <= n_bw + 1;
            if (ovr_evt) n_ovr <= n_ovr + 1;
        end
    end

    function automatic logic [7:0] pat(input int fid, input int i);
        return 8'((fid * 5 + i * 3 + (i >> 7)) & 32'h7F);
    endfunction

    function automatic int exp_len(input int n);
        return (n > MAXF) ? MAXF : n;
    endfunction

    function automatic logic [15:0] exp_stat(input logic [15:0] orig, input int n, input logic err);
        logic [15:0] s;
        s = (orig & ~16'h883F) | 16'h0800;
        if (n > MAXF) s = s | 16'h0020;
        if (n < MINF) s = s | 16'h0010;
        if (err)      s = s | 16'h0001;
        return s;
    endfunction

    function automatic logic [31:0] bptr(input int idx);
        return 32'h1000_0000 + 32'(idx) * 32'h0001_0000;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic kick(input logic [31:0] v);
        act_wr = 1'b1; act_wdata = v; tick(1);
        act_wr = 1'b0; act_wdata = '0;
    endtask

    task automatic set_base(input int v);
        base_wr = 1'b1; base_wdata = DAW'(v); tick(1);
        base_wr = 1'b0;
    endtask

    task automatic arm(input int b, input int idx, input logic [15:0] stat);
        h_dwe = 1'b1; h_daddr = 6'(b + idx); h_ddata = {stat, 16'h0, bptr(idx)}; tick(1);
        h_dwe = 1'b0;
    endtask

    task automatic guard();
        h_bwe = 1'b1; h_baddr = 11'(MAXF); tick(1);
        h_bwe = 1'b0;
    endtask

    task automatic send_frame(input int n, input logic err, input int fid, input logic gaps);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_data = pat(fid, i);
            in_last = (i == n - 1); in_err = err && (i == n - 1);
            tick(1);
            if (gaps && ($urandom % 5 == 0)) begin
                in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0; tick(1);
            end
        end
        in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
    endtask

    task automatic verify(input string req, input int b, input int idx, input logic [15:0] orig,
                          input int n, input logic err, input int fid);
        logic [63:0] d;
        int bad;
        d = dmem[6'(b + idx)];
        check(req, "status", 64'(d[63:48]), 64'(exp_stat(orig, n, err)));
        check(req, "length", 64'(d[47:32]), 64'(exp_len(n)));
        bad = 0;
        for (int i = 0; i < exp_len(n); i++)
            if (bmem[11'(i)] !== pat(fid, i)) bad++;
        check("R3", "payload mismatches", 64'(bad), 64'd0);
        check("R3", "buffer region", 64'(hi_seen), 64'(bptr(idx) >> 11));
        if (n >= MAXF) check("R7", "byte past limit", 64'(bmem[11'(MAXF)]), 64'hEE);
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual still running, expected finished");
        finish_up();
    end

    initial begin : main
        logic [15:0] org [5];
        int c_dmw, c_bw, c_ovr, e, fid, n;
        logic err;
        void'($urandom(32'd2718));
        for (int i = 0; i < 64; i++) dmem[i] = '0;

        // R1: reset state
        tick(5);
        check("R1", "poll_active in reset", 64'(poll_active), 64'd0);
        check("R1", "dm_rd/dm_wr in reset", 64'({dm_rd, dm_wr}), 64'd0);
        check("R1", "buf_we/ovr in reset", 64'({buf_we, ovr_evt}), 64'd0);
        rst_n = 1'b1;
        tick(3);
        check("R1", "idle after reset", 64'({poll_active, dm_rd, dm_wr}), 64'd0);

        // Directed ring at base 8: four descriptors plus an empty sentinel after the wrap.
        set_base(8);
        arm(8, 0, 16'h803F);
        arm(8, 1, 16'h8040);
        arm(8, 2, 16'h8000);
        arm(8, 3, 16'hA000);
        arm(8, 4, 16'h8000);
        kick(32'h0000_0001);
        tick(4);
        check("R2", "kick without bit 24", 64'(poll_active), 64'd0);
        kick(32'h0100_0000);
        tick(5);
        check("R2", "kick with bit 24", 64'(poll_active), 64'd1);

        guard(); send_frame(64, 1'b0, 1, 1'b0); tick(4);
        verify("R4", 8, 0, 16'h803F, 64, 1'b0, 1);
        guard(); send_frame(63, 1'b0, 2, 1'b1); tick(4);
        verify("R8", 8, 1, 16'h8040, 63, 1'b0, 2);
        guard(); send_frame(MAXF, 1'b0, 3, 1'b0); tick(4);
        verify("R7", 8, 2, 16'h8000, MAXF, 1'b0, 3);
        guard(); send_frame(1600, 1'b1, 4, 1'b1); tick(4);
        verify("R9", 8, 3, 16'hA000, 1600, 1'b1, 4);
        tick(4);
        check("R6", "halt on owned descriptor", 64'(poll_active), 64'd0);
        check("R5", "sentinel past wrap untouched", dmem[12], {16'h8000, 16'h0, bptr(4)});
        check("R6", "owned descriptor untouched", 64'(dmem[8][63:48]), 64'(exp_stat(16'h803F, 64, 1'b0)));

        // R10: frame while halted is dropped.
        c_dmw = n_dmw; c_bw = n_bw; c_ovr = n_ovr;
        send_frame(20, 1'b0, 9, 1'b0); tick(4);
        check("R10", "overrun pulses", 64'(n_ovr - c_ovr), 64'd1);
        check("R10", "descriptor writes", 64'(n_dmw - c_dmw), 64'd0);
        check("R10", "buffer writes", 64'(n_bw - c_bw), 64'd0);

        // R11: base write while active is ignored; R5: wrap went back to index 0.
        arm(8, 0, 16'h8000);
        kick(32'h0100_0000);
        tick(5);
        set_base(40);
        guard(); send_frame(100, 1'b0, 10, 1'b0); tick(4);
        verify("R11", 8, 0, 16'h8000, 100, 1'b0, 10);
        tick(4);
        check("R6", "halt at used descriptor", 64'(poll_active), 64'd0);

        // Random run on a five-entry ring at base 24 (base write while halted).
        set_base(24);
        for (int i = 0; i < 5; i++) begin
            org[i] = 16'h8000 | (i == 4 ? 16'h2000 : 16'h0) | 16'(($urandom % 32) << 6) | 16'($urandom % 64);
            org[i][ST_LAST_B] = 1'b0;
            arm(24, i, org[i]);
        end
        kick(32'h0100_0000);
        tick(5);
        e = 0;
        for (int k = 0; k < 40; k++) begin
            fid = 20 + k;
            n = ($urandom % 8 == 0) ? 1510 + int'($urandom % 30) : 1 + int'($urandom % 200);
            err = ($urandom % 4 == 0);
            guard(); send_frame(n, err, fid, 1'b1); tick(4);
            verify((k == 0) ? "R11" : "R4", 24, e, org[e], n, err, fid);
            check("R5", "still polling", 64'(poll_active), 64'd1);
            org[e] = 16'h8000 | (e == 4 ? 16'h2000 : 16'h0) | 16'($urandom % 64);
            arm(24, e, org[e]);
            e = (e == 4) ? 0 : e + 1;
        end

        finish_up();
    end

    localparam int ST_LAST_B = 11;

endmodule